// File: doc/BRIEF.md
# SPI-fed LCD refresh adapter

This block lets a serial port fed by DMA refresh a monochrome LCD panel that has no controller of its own. The host repeats the framebuffer over SPI without a break. The adapter packs the serial bits into 4-bit pixel groups and derives the pixel clock from the serial clock (SCK divided by four). It also counts pixel groups to place a line-latch pulse and counts lines to place a frame marker and a polarity signal that alternates every frame. Every register runs on SCK. The data bus and the line and frame signals change on rising SCK edges. The pixel clock changes on falling SCK edges, so the data is stable when the panel samples it.

The serial stream cannot be stalled. SPI has no back-pressure, so the adapter has no ready signal. Chip-select low plays the part of "valid", and every rising SCK edge while it is low takes one bit. Raising chip-select, or pulling reset low, clears the adapter at once. The next bit is then treated as the first pixel of line 0 of a new frame, which lets software line up the adapter with the start of each DMA transfer. With the default geometry a line is 128 groups (512 pixels) and a frame is 64 lines, so a 3 MHz SCK gives a 750 kHz pixel clock and about 90 frames per second.

Top module: `lcd_spi_refresh`

## Requirements
- R1: While cs_n is low, mosi is taken on every rising sck edge. On every fourth such edge, pix_data loads the last four bits with the first-received bit in bit 3 (leftmost pixel) and the last in bit 0. It holds that value until the next load.
- R2: pix_clk is low until the first group has loaded. After that it changes only on falling sck edges and has a period of four sck cycles. It rises at the falling edge that follows a pix_data load and falls two sck cycles later, so pix_data never changes while pix_clk is high.
- R3: line_latch goes high at the rising sck edge that loads the first group of every line except the very first, which is after the 128th group of the previous line. It stays high for 4*LATCH_PCLKS sck cycles (default 4) and is low at all other times.
- R4: frame_mark is high while line 0 of each frame is being sent (64 lines per frame). It stays high through the line_latch pulse that ends line 0 and falls together with that pulse.
- R5: polarity is 0 during the first frame after a clear. It inverts at the rising edge that loads the first group of each later frame, which is the same edge at which frame_mark rises.
- R6: rst_n low or cs_n high clears the block asynchronously: pix_data, pix_clk, line_latch, frame_mark and polarity read 0, and mosi is ignored. When cs_n falls again, the first bit starts group 0 of line 0 of a new first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high clears and resynchronises |
| mosi | input | 1 | Serial pixel data, one pixel per bit |
| pix_data | output | NIB_W (4) | Parallel pixel group to the panel |
| pix_clk | output | 1 | Pixel clock, sck divided by four |
| line_latch | output | 1 | High pulse after each complete line |
| frame_mark | output | 1 | High over line 0 of each frame |
| polarity | output | 1 | Drive polarity, inverted every frame |

## Verification
A seeded random bit stream runs for just over two full frames. It exposes errors in the order of the bits within a group and in the off-by-one positions of the line pulse, the frame marker and the polarity step. After chip-select is raised mid-line, the stream restarts with a fixed 0xA5 byte pattern and then with all ones. The repeated pattern makes bit-order reversal and a wrong group phase after resynchronisation show up. The all-ones run checks that the line and frame timing do not depend on the pixel values.

// File: rtl/lcd_refresh_pkg.sv
package lcd_refresh_pkg;

  // Counter width that can hold the values 0 .. n-1 (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Counter width that can hold the values 0 .. n.
  function automatic int unsigned cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lcd_nib_deser.sv
module lcd_nib_deser #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned PH_W  = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             din,
  output logic [NIB_W-1:0] nib,
  output logic [PH_W-1:0]  phase,
  output logic             load
);
  logic [NIB_W-2:0] shreg;
  logic [NIB_W-1:0] next_word;

  // The newest bit enters at the bottom, so the first bit ends up in the MSB.
  assign next_word = {shreg, din};
  assign load      = (phase == PH_W'(NIB_W - 1));

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      shreg <= '0;
      nib   <= '0;
      phase <= '0;
    end else begin
      shreg <= next_word[NIB_W-2:0];
      phase <= load ? '0 : phase + 1'b1;
      if (load) nib <= next_word;
    end
  end
endmodule

// File: rtl/lcd_pclk_gen.sv
module lcd_pclk_gen #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned PH_W  = 2
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            started,
  input  logic [PH_W-1:0] phase,
  output logic            pclk
);
  localparam logic [PH_W-1:0] HALF = PH_W'(NIB_W / 2);

  // Falling-edge register: high for the first half of each group period,
  // half an sck cycle after the data changed.
  always_ff @(negedge clk or posedge clr) begin
    if (clr) pclk <= 1'b0;
    else     pclk <= started && (phase < HALF);
  end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_refresh_pkg::*;
#(
  parameter int unsigned NIBS      = 128,
  parameter int unsigned LINES     = 64,
  parameter int unsigned LATCH_SCK = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic load,
  output logic started,
  output logic line_latch,
  output logic frame_mark,
  output logic polarity
);
  localparam int unsigned NW = idx_w(NIBS);
  localparam int unsigned LW = idx_w(LINES);
  localparam int unsigned CW = cnt_w(LATCH_SCK);

  logic [NW-1:0] ncnt;
  logic [LW-1:0] lcnt;
  logic [CW-1:0] lat_cnt;
  logic          pol;
  logic          line_end;
  logic          frame_end;

  assign line_end  = (ncnt == NW'(NIBS - 1));
  assign frame_end = (lcnt == LW'(LINES - 1));

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      started <= 1'b0;
      ncnt    <= '0;
      lcnt    <= '0;
      lat_cnt <= '0;
      pol     <= 1'b0;
    end else begin
      if (lat_cnt != '0) lat_cnt <= lat_cnt - 1'b1;
      if (load) begin
        if (!started) begin
          started <= 1'b1;
        end else if (line_end) begin
          ncnt    <= '0;
          lat_cnt <= CW'(LATCH_SCK);
          if (frame_end) begin
            lcnt <= '0;
            pol  <= ~pol;
          end else begin
            lcnt <= lcnt + 1'b1;
          end
        end else begin
          ncnt <= ncnt + 1'b1;
        end
      end
    end
  end

  assign line_latch = (lat_cnt != '0);
  assign frame_mark = started &&
                      ((lcnt == '0) || ((lcnt == LW'(1)) && (lat_cnt != '0)));
  assign polarity   = pol;
endmodule

// File: rtl/lcd_spi_refresh.sv
module lcd_spi_refresh
  import lcd_refresh_pkg::*;
#(
  parameter int unsigned NIB_W           = 4,
  parameter int unsigned NIBS_PER_LINE   = 128,
  parameter int unsigned LINES_PER_FRAME = 64,
  parameter int unsigned LATCH_PCLKS     = 1
) (
  input  logic             sck,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             mosi,
  output logic [NIB_W-1:0] pix_data,
  output logic             pix_clk,
  output logic             line_latch,
  output logic             frame_mark,
  output logic             polarity
);
  localparam int unsigned PH_W      = idx_w(NIB_W);
  localparam int unsigned LATCH_SCK = LATCH_PCLKS * NIB_W;

  logic            clr;
  logic            load;
  logic            started;
  logic [PH_W-1:0] phase;

  // Deselect doubles as a resynchronising clear (R6).
  assign clr = ~rst_n | cs_n;

  lcd_nib_deser #(.NIB_W(NIB_W), .PH_W(PH_W)) i_deser (
    .clk(sck), .clr(clr), .din(mosi),
    .nib(pix_data), .phase(phase), .load(load)
  );

  lcd_pclk_gen #(.NIB_W(NIB_W), .PH_W(PH_W)) i_pclk (
    .clk(sck), .clr(clr), .started(started), .phase(phase), .pclk(pix_clk)
  );

  lcd_raster_timer #(
    .NIBS(NIBS_PER_LINE), .LINES(LINES_PER_FRAME), .LATCH_SCK(LATCH_SCK)
  ) i_raster (
    .clk(sck), .clr(clr), .load(load), .started(started),
    .line_latch(line_latch), .frame_mark(frame_mark), .polarity(polarity)
  );
endmodule

// File: rtl/lcd_spi_refresh_chk.sv
module lcd_spi_refresh_chk #(
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned LATCH_SCK = 4
) (
  input logic             sck,
  input logic             clr,
  input logic [NIB_W-1:0] pix_data,
  input logic             pix_clk,
  input logic             line_latch,
  input logic             frame_mark,
  input logic             polarity
);
  logic [15:0] lat_run;

  always_ff @(posedge sck or posedge clr) begin
    if (clr)                             lat_run <= '0;
    else if (!line_latch)                lat_run <= '0;
    else if (lat_run != 16'hFFFF)        lat_run <= lat_run + 1'b1;
  end

  assert_data_quiet_pclk_R2: assert property (@(posedge sck) disable iff (clr)
    !$stable(pix_data) |-> !$past(pix_clk));

  assert_latch_width_R3: assert property (@(posedge sck) disable iff (clr)
    lat_run <= 16'(LATCH_SCK));

  assert_frame_ends_with_latch_R4: assert property (@(posedge sck) disable iff (clr)
    $fell(frame_mark) |-> $fell(line_latch));

  assert_pol_at_frame_R5: assert property (@(posedge sck) disable iff (clr)
    !$stable(polarity) |-> $rose(frame_mark));

  assert_cleared_outputs_R6: assert property (@(posedge sck)
    (clr && $past(clr)) |->
      (pix_data == '0 && !pix_clk && !line_latch && !frame_mark && !polarity));
endmodule

bind lcd_spi_refresh lcd_spi_refresh_chk #(.NIB_W(NIB_W), .LATCH_SCK(LATCH_SCK)) i_chk (
  .sck(sck), .clr(clr), .pix_data(pix_data), .pix_clk(pix_clk),
  .line_latch(line_latch), .frame_mark(frame_mark), .polarity(polarity)
);

// File: tb/test_lcd_spi_refresh.sv
module test_lcd_spi_refresh;
  localparam int P          = 20;
  localparam int NIBS       = 128;
  localparam int LINES      = 64;
  localparam int LATCH_P    = 1;
  localparam int LINE_BITS  = NIBS * 4;
  localparam int FRAME_BITS = LINE_BITS * LINES;
  localparam int LAT_SCK    = LATCH_P * 4;
  localparam int MAXB       = 2 * FRAME_BITS + 2048;
  localparam int WD_CYCLES  = 150000;

  logic sck = 1'b0;
  logic rst_n = 1'b1;
  logic cs_n = 1'b0;
  logic mosi = 1'b0;
  logic [3:0] pix_data;
  logic pix_clk, line_latch, frame_mark, polarity;

  int errors = 0;
  int checks = 0;
  int n = 0;
  bit done = 1'b0;
  bit bits [0:MAXB-1];

  always #(P/2) sck = ~sck;

  lcd_spi_refresh #(
    .NIB_W(4), .NIBS_PER_LINE(NIBS), .LINES_PER_FRAME(LINES), .LATCH_PCLKS(LATCH_P)
  ) i_lcd_spi_refresh (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi),
    .pix_data(pix_data), .pix_clk(pix_clk), .line_latch(line_latch),
    .frame_mark(frame_mark), .polarity(polarity)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (bit %0d)", tag, act, exp, n);
    end
  endtask

  function automatic int exp_data(input int k);
    int g;
    if (k < 4) return 0;
    g = k / 4 - 1;
    return {bits[4*g], bits[4*g+1], bits[4*g+2], bits[4*g+3]};
  endfunction

  function automatic int exp_latch(input int k);
    if (k < 4) return 0;
    return (((k-4) / LINE_BITS) >= 1 && ((k-4) % LINE_BITS) < LAT_SCK) ? 1 : 0;
  endfunction

  function automatic int exp_frame(input int k);
    int ln;
    if (k < 4) return 0;
    ln = ((k-4) / LINE_BITS) % LINES;
    return (ln == 0 || (ln == 1 && ((k-4) % LINE_BITS) < LAT_SCK)) ? 1 : 0;
  endfunction

  function automatic int exp_pol(input int k);
    if (k < 4) return 0;
    return (((k-4) / FRAME_BITS) % 2);
  endfunction

  function automatic int exp_pclk(input int k);
    if (k < 4) return 0;
    return (((k-4) % 4) < 2) ? 1 : 0;
  endfunction

  task automatic check_idle(input string tag);
    check(tag, pix_data, 0);
    check(tag, pix_clk, 0);
    check(tag, line_latch, 0);
    check(tag, frame_mark, 0);
    check(tag, polarity, 0);
  endtask

  // Called just after a falling edge; returns at the same point.
  task automatic stream(input int cnt, input int mode);
    for (int i = 0; i < cnt; i++) begin
      bit b;
      case (mode)
        0:       b = 1'($urandom());
        1:       b = 1'(8'hA5 >> (7 - (n % 8)));
        default: b = 1'b1;
      endcase
      bits[n] = b;
      mosi = b;
      @(posedge sck);
      n++;
      #(P/4);
      check("R1", pix_data, exp_data(n));
      check("R3", line_latch, exp_latch(n));
      check("R4", frame_mark, exp_frame(n));
      check("R5", polarity, exp_pol(n));
      @(negedge sck);
      #(P/4);
      check("R2", pix_clk, exp_pclk(n));
      check("R1", pix_data, exp_data(n));
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge sck);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    #1;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    repeat (3) @(negedge sck);
    #(P/4);
    check_idle("R6");
    rst_n = 1'b1;
    // mosi toggles while deselected: must have no effect (R6)
    for (int i = 0; i < 6; i++) begin
      mosi = ~mosi;
      @(negedge sck);
      #(P/4);
    end
    check_idle("R6");

    cs_n = 1'b0;
    n = 0;
    stream(2 * FRAME_BITS + 600, 0);

    // Resynchronise mid-line
    cs_n = 1'b1;
    #1;
    check_idle("R6");
    for (int i = 0; i < 3; i++) begin
      mosi = ~mosi;
      @(negedge sck);
      #(P/4);
    end
    check_idle("R6");
    cs_n = 1'b0;
    n = 0;
    stream(1100, 1);
    stream(700, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule